// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a general-purpose timer. A counter of parameterised width (16 bits by default) advances on a prescaled copy of the system clock. The prescale factor is 1, 2, 4 or 8. Two compare registers, A and B, are checked against the counter on every prescaled tick. A match can raise a sticky flag, can restart the counter, and can drive a pin.

The pin takes one of two functions. In the first it is a plain port bit driven from a control field. In the second it is a timer output, which set, clear or toggle actions change on a match of compare B. In PWM mode compare A sets the pin and compare B clears it. Timer-driven pin changes take effect at the falling clock edge that follows the tick.

Software reaches the channel through a small register bus. The counter is cleared only by writing zero to it; stopping the channel leaves the count as it is. When the pin is handed from port to timer, it holds its level until a compare event changes it.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control word, counter and flags read 0, both compare registers read 0xFFFF and the pin is low. Addresses: 0 control, 1 counter, 2 compare A, 3 compare B, 4 flags.
- R2: Control bit 0 is the run bit. Control bits 2:1 select the tick rate: 0 gives every clock, 1 every 2nd, 2 every 4th, 3 every 8th. The counter gains one per tick.
- R3: While the run bit is 0, the counter and the prescale phase hold. Setting the run bit again leaves the count unchanged.
- R4: Flag bit 0 (compare A) and flag bit 1 (compare B) are set on a tick taken while the counter equals that compare value. A flag stays set until flag address 4 is read with the bit at 1 and later written with the bit at 0. A 0 written without that earlier read has no effect, and writing a 1 keeps the flag.
- R5: Control bits 4:3 select counter clearing: 0 none, 1 on a compare A match, 2 on a compare B match. A match that clears loads 0 in place of the increment, so the period is the compare value plus one ticks.
- R6: Outside PWM mode, control bits 7:6 choose the pin action on a compare B match: 0 no change, 1 drive low, 2 drive high, 3 invert.
- R7: With control bit 5 (PWM) set, a compare A match drives the timer output high and a compare B match drives it low. Bits 7:6 are ignored. B wins if both match on the same tick.
- R8: With control bit 8 at 0 the pin follows control bit 9, the port level.
- R9: When a control write changes bit 8 from 0 to 1, the timer output takes the port level held before that write. The pin keeps that level until a compare event changes it.
- R10: A compare action on the same clock as that handover is applied to the handed-over level.
- R11: A timer-driven pin change appears at the falling clock edge after the rising edge that took the matching tick.
- R12: A counter write wins over a tick in the same clock and restarts the prescale phase. The counter wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from bus_addr |
| match_flag | output | 2 | Sticky compare-match flags (bit 0 A, bit 1 B) |
| tmr_pin | output | 1 | Channel pin |

## Verification
Register reads are combinational, so a read is checked in the same clock it is issued. A counter or flag change is due right after the rising edge that takes the tick. A pin change is due after the following falling edge: the pin is compared three quarters of a period after the tick edge. For R11 it is also checked as still unchanged a quarter period after that edge. Each expectation carries the clock index in which it falls due, worked out from the write edge that started the run. The monitor compares only in that clock, and any item left unchecked past its clock counts as a mismatch.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   localparam int NUM_CMP   = 2;
   localparam int DIV_SEL_W = 2;

   localparam int ADR_CTRL = 0;
   localparam int ADR_CNT  = 1;
   localparam int ADR_CMPA = 2;
   localparam int ADR_CMPB = 3;
   localparam int ADR_FLAG = 4;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_LOW  = 2'd1,
      ACT_HIGH = 2'd2,
      ACT_FLIP = 2'd3
   } pin_act_e;

   typedef enum logic [1:0] {
      CLR_NONE = 2'd0,
      CLR_ON_A = 2'd1,
      CLR_ON_B = 2'd2,
      CLR_RSVD = 2'd3
   } clr_sel_e;

   // bit 9 port level, 8 timer pin, 7:6 action, 5 pwm, 4:3 clear, 2:1 divide, 0 run
   typedef struct packed {
      logic                 port_lvl;
      logic                 timer_pin;
      pin_act_e             act;
      logic                 pwm;
      clr_sel_e             clr;
      logic [DIV_SEL_W-1:0] div;
      logic                 run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);
   localparam int PC_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("cmt_prescale: SEL_W out of range");
   end

   logic [PC_W-1:0] phase_q;
   logic [PC_W-1:0] mask;

   always_comb begin
      mask = PC_W'((32'd1 << div_sel) - 32'd1);
      tick = run && ((phase_q & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (run)     phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/cmt_count.sv
module cmt_count import cmt_pkg::*; #(
   parameter int CNT_W = 16,
   parameter int NCMP  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       wr_en,
   input  logic [CNT_W-1:0]           wr_val,
   input  logic [NCMP-1:0][CNT_W-1:0] cmp_vals,
   input  clr_sel_e                   clr_sel,
   output logic [CNT_W-1:0]           cnt,
   output logic [NCMP-1:0]            hit
);
   if (NCMP != 2) begin : g_bad_ncmp
      $error("cmt_count: two compare registers expected");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             clr_hit;

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      assign hit[i] = tick && (cnt_q == cmp_vals[i]);
   end

   always_comb begin
      case (clr_sel)
         CLR_ON_A: clr_hit = hit[0];
         CLR_ON_B: clr_hit = hit[1];
         default:  clr_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wr_en)  cnt_q <= wr_val;
      else if (tick)   cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/cmt_pinout.sv
module cmt_pinout import cmt_pkg::*; #(
   parameter bit LATE_HALF = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] hit,
   input  logic       pwm,
   input  pin_act_e   act,
   input  logic       timer_pin,
   input  logic       port_lvl,
   input  logic       handover,
   output logic       tout,
   output logic       pin
);
   logic tout_q;
   logic base;
   logic tout_d;
   logic pin_d;

   always_comb begin
      base   = handover ? port_lvl : tout_q;
      tout_d = base;
      if (pwm) begin
         if (hit[1])      tout_d = 1'b0;
         else if (hit[0]) tout_d = 1'b1;
      end else if (hit[1]) begin
         case (act)
            ACT_LOW:  tout_d = 1'b0;
            ACT_HIGH: tout_d = 1'b1;
            ACT_FLIP: tout_d = ~base;
            default:  tout_d = base;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tout_q <= 1'b0;
      else        tout_q <= tout_d;
   end

   assign tout  = tout_q;
   assign pin_d = timer_pin ? tout_q : port_lvl;

   if (LATE_HALF) begin : g_late
      logic pin_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= pin_d;
      end
      assign pin = pin_q;
   end else begin : g_same
      assign pin = pin_d;
   end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel import cmt_pkg::*; #(
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 3,
   parameter bit LATE_HALF = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   output logic [NUM_CMP-1:0] match_flag,
   output logic               tmr_pin
);
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("cmt_channel: CNT_W too small for the control word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("cmt_channel: ADDR_W too small for the register map");
   end

   ctrl_t                         ctrl_q;
   ctrl_t                         ctrl_new;
   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
   logic [NUM_CMP-1:0]            flag_q;
   logic [NUM_CMP-1:0]            armed_q;
   logic [NUM_CMP-1:0]            flag_clr;
   logic [NUM_CMP-1:0]            hit;
   logic [CNT_W-1:0]              cnt_q;
   logic                          tick;
   logic                          tout;
   logic                          handover;
   logic wr_ctrl, wr_cnt, wr_cmpa, wr_cmpb, wr_flag, rd_flag;
   logic run_w, pwm_w, tp_w, port_w;
   logic [1:0] clr_w;

   always_comb begin
      wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
      wr_cnt  = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_CNT));
      wr_cmpa = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_CMPA));
      wr_cmpb = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_CMPB));
      wr_flag = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_FLAG));
      rd_flag = bus_sel && !bus_wr && (bus_addr == ADDR_W'(ADR_FLAG));
      ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);
      handover = wr_ctrl && ctrl_new.timer_pin && !ctrl_q.timer_pin;
      flag_clr = wr_flag ? (armed_q & ~bus_wdata[NUM_CMP-1:0]) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cmp_q   <= '1;
         flag_q  <= '0;
         armed_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q   <= ctrl_new;
         if (wr_cmpa) cmp_q[0] <= bus_wdata;
         if (wr_cmpb) cmp_q[1] <= bus_wdata;
         flag_q <= (flag_q & ~flag_clr) | hit;
         if (rd_flag) armed_q <= armed_q | flag_q;
         else         armed_q <= armed_q & ~flag_clr;
      end
   end

   cmt_prescale #(.SEL_W(DIV_SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .restart (wr_cnt),
      .div_sel (ctrl_q.div),
      .tick    (tick)
   );

   cmt_count #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_en    (wr_cnt),
      .wr_val   (bus_wdata),
      .cmp_vals (cmp_q),
      .clr_sel  (ctrl_q.clr),
      .cnt      (cnt_q),
      .hit      (hit)
   );

   cmt_pinout #(.LATE_HALF(LATE_HALF)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .pwm       (ctrl_q.pwm),
      .act       (ctrl_q.act),
      .timer_pin (ctrl_q.timer_pin),
      .port_lvl  (ctrl_q.port_lvl),
      .handover  (handover),
      .tout      (tout),
      .pin       (tmr_pin)
   );

   always_comb begin
      case (bus_addr)
         ADDR_W'(ADR_CTRL): bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
         ADDR_W'(ADR_CNT):  bus_rdata = cnt_q;
         ADDR_W'(ADR_CMPA): bus_rdata = cmp_q[0];
         ADDR_W'(ADR_CMPB): bus_rdata = cmp_q[1];
         ADDR_W'(ADR_FLAG): bus_rdata = {{(CNT_W-NUM_CMP){1'b0}}, flag_q};
         default:           bus_rdata = '0;
      endcase
   end

   assign match_flag = flag_q;
   assign run_w  = ctrl_q.run;
   assign pwm_w  = ctrl_q.pwm;
   assign tp_w   = ctrl_q.timer_pin;
   assign port_w = ctrl_q.port_lvl;
   assign clr_w  = ctrl_q.clr;
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             cnt_wr,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_a,
   input logic [CNT_W-1:0] cmp_b,
   input logic [1:0]       clr_sel,
   input logic             pwm,
   input logic             tout,
   input logic [1:0]       flags,
   input logic             flag_wr,
   input logic             pin_fn,
   input logic             port_lvl,
   input logic             pin
);
   // R3: a stopped channel keeps its count unless software writes it
   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> (cnt == $past(cnt)));

   // R12: all ones wraps to zero on a tick
   p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && (cnt == '1)) |=> (cnt == '0));

   // R5: clear on compare A restarts the count
   p_clear_on_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && (clr_sel == 2'd1) && (cnt == cmp_a)) |=> (cnt == '0));

   // R7: compare B drives the PWM output low
   p_pwm_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && tick && (cnt == cmp_b)) |=> !tout);

   // R4: a flag without a flag write stays set
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !flag_wr) |=> flags[0]);

   // R8: port function drives the port level
   p_port_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_fn |-> (pin == port_lvl));
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run_w),
   .cnt_wr   (wr_cnt),
   .tick     (tick),
   .cnt      (cnt_q),
   .cmp_a    (cmp_q[0]),
   .cmp_b    (cmp_q[1]),
   .clr_sel  (clr_w),
   .pwm      (pwm_w),
   .tout     (tout),
   .flags    (flag_q),
   .flag_wr  (wr_flag),
   .pin_fn   (tp_w),
   .port_lvl (port_w),
   .pin      (tmr_pin)
);

// File: tb/test_cmt_channel.sv
`timescale 1ns/1ps
module test_cmt_channel;
   localparam int A_CTRL = 0, A_CNT = 1, A_CMPA = 2, A_CMPB = 3, A_FLAG = 4;
   localparam int K_RD = 0, K_PIN = 1, K_EARLY = 2;

   typedef struct {
      int          due;
      int          kind;
      logic [15:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  match_flag;
   logic        tmr_pin;

   int    ncyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   item_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) ncyc <= ncyc + 1;

   cmt_channel i_cmt_channel (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .match_flag(match_flag), .tmr_pin(tmr_pin)
   );

   function automatic logic [15:0] mk(bit run, int dv, int clr, bit pwm, int act, bit tp, bit port);
      return {6'b0, port, tp, 2'(act), pwm, 2'(clr), 2'(dv), run};
   endfunction

   task automatic push(int due, int kind, logic [15:0] e, string tag);
      item_t it;
      it.due = due; it.kind = kind; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(int a, logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(int a, logic [15:0] e, string tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
      push(ncyc, K_RD, e, tag);
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic scan(bit late);
      for (int i = sb.size() - 1; i >= 0; i--) begin
         logic [15:0] act;
         bit          take;
         take = 1'b0;
         if (late && sb[i].due < ncyc) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: actual=missed expected=%h at cycle %0d", sb[i].tag, sb[i].exp, sb[i].due);
            sb.delete(i);
         end else if (sb[i].due == ncyc && ((sb[i].kind == K_EARLY) != late)) begin
            take = 1'b1;
         end
         if (take) begin
            act = (sb[i].kind == K_RD) ? bus_rdata : {15'b0, tmr_pin};
            n_cmp++;
            if (act !== sb[i].exp) begin
               n_bad++;
               $display("FAIL %s: actual=%h expected=%h cycle %0d", sb[i].tag, act, sb[i].exp, ncyc);
            end
            sb.delete(i);
         end
      end
   endtask

   // monitor: early phase 1ns after the rising edge, main phase 3ns after
   initial begin
      forever begin
         @(posedge clk); #1;
         scan(1'b0);
         #2;
         scan(1'b1);
      end
   end

   task automatic finish_run();
      foreach (sb[i]) begin
         n_cmp++; n_bad++;
         $display("FAIL %s: actual=unchecked expected=%h", sb[i].tag, sb[i].exp);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #800000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=completed");
      finish_run();
   end

   initial begin
      int e;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd(A_CTRL, 16'h0000, "R1 ctrl");
      rd(A_CNT,  16'h0000, "R1 count");
      rd(A_CMPA, 16'hFFFF, "R1 cmpA");
      rd(A_CMPB, 16'hFFFF, "R1 cmpB");
      rd(A_FLAG, 16'h0000, "R1 flags");
      push(ncyc, K_PIN, 16'h0, "R1 pin");
      idle(1);

      // R2 divide by 4, R3 hold and restart
      wr(A_CNT, 16'h0);
      wr(A_CTRL, mk(1, 2, 0, 0, 0, 0, 0));
      rd(A_CNT, 16'd0, "R2 start");
      idle(6);
      rd(A_CNT, 16'd1, "R2 after 7 clocks");
      rd(A_CNT, 16'd2, "R2 after 8 clocks");
      wr(A_CTRL, mk(0, 2, 0, 0, 0, 0, 0));
      idle(5);
      rd(A_CNT, 16'd2, "R3 stopped hold");
      wr(A_CTRL, mk(1, 2, 0, 0, 0, 0, 0));
      rd(A_CNT, 16'd2, "R3 restart keeps count");
      wr(A_CTRL, mk(0, 2, 0, 0, 0, 0, 0));

      // R12 wrap, R4 flags
      wr(A_CNT, 16'hFFFF);
      wr(A_CTRL, mk(1, 0, 0, 0, 0, 0, 0));
      rd(A_CNT, 16'hFFFF, "R12 before wrap");
      rd(A_CNT, 16'h0000, "R12 wrap to zero");
      wr(A_CTRL, mk(0, 0, 0, 0, 0, 0, 0));
      wr(A_FLAG, 16'h0);
      rd(A_FLAG, 16'h3, "R4 flags set, unread clear ignored");
      wr(A_FLAG, 16'h2);
      rd(A_FLAG, 16'h2, "R4 clear bit0 keep bit1");
      wr(A_CTRL, mk(1, 0, 0, 0, 0, 0, 0));
      wr(A_CNT, 16'h0100);
      rd(A_CNT, 16'h0100, "R12 write wins over tick");
      wr(A_CTRL, mk(0, 0, 0, 0, 0, 0, 0));

      // R5 clear on A, R6 toggle on B, R11 falling-edge pin
      wr(A_CMPA, 16'd4);
      wr(A_CMPB, 16'd2);
      wr(A_CNT, 16'd0);
      wr(A_CTRL, mk(1, 0, 1, 0, 3, 1, 0));
      e = ncyc;
      push(e + 2, K_PIN,   16'h0, "R6 toggle before match");
      push(e + 3, K_EARLY, 16'h0, "R11 pin unchanged at rising edge");
      push(e + 3, K_PIN,   16'h1, "R6 R11 toggle after falling edge");
      push(e + 7, K_PIN,   16'h1, "R6 holds between matches");
      push(e + 8, K_PIN,   16'h0, "R6 second toggle");
      rd(A_CNT, 16'd0, "R5 start");
      idle(3);
      rd(A_CNT, 16'd4, "R5 at compare");
      rd(A_CNT, 16'd0, "R5 period compare+1");
      idle(3);
      wr(A_CTRL, mk(0, 0, 1, 0, 3, 1, 0));
      idle(1);

      // R8 port, R9 handover
      wr(A_CTRL, mk(0, 0, 0, 0, 0, 0, 1));
      push(ncyc, K_PIN, 16'h1, "R8 port level high");
      idle(1);
      wr(A_CTRL, mk(0, 0, 0, 0, 0, 1, 0));
      e = ncyc;
      push(e,     K_PIN, 16'h1, "R9 handover keeps level");
      push(e + 3, K_PIN, 16'h1, "R9 level held");
      idle(4);

      // R10 match in handover clock
      wr(A_CTRL, mk(0, 0, 0, 0, 0, 0, 0));
      push(ncyc, K_PIN, 16'h0, "R8 port level low");
      wr(A_CMPB, 16'd5);
      wr(A_CNT, 16'd3);
      wr(A_CTRL, mk(1, 0, 0, 0, 3, 0, 0));
      idle(2);
      wr(A_CTRL, mk(1, 0, 0, 0, 3, 1, 0));
      push(ncyc, K_PIN, 16'h1, "R10 action on handover clock");
      idle(1);
      wr(A_CTRL, mk(0, 0, 0, 0, 3, 1, 0));

      // R6 clear and set actions
      wr(A_CMPB, 16'd1);
      wr(A_CNT, 16'd0);
      wr(A_CTRL, mk(1, 0, 0, 0, 1, 1, 0));
      e = ncyc;
      push(e + 1, K_PIN, 16'h1, "R6 before clear action");
      push(e + 2, K_PIN, 16'h0, "R6 clear action");
      idle(3);
      wr(A_CTRL, mk(0, 0, 0, 0, 1, 1, 0));
      wr(A_CNT, 16'd0);
      wr(A_CTRL, mk(1, 0, 0, 0, 2, 1, 0));
      e = ncyc;
      push(e + 1, K_PIN, 16'h0, "R6 before set action");
      push(e + 2, K_PIN, 16'h1, "R6 set action");
      idle(3);
      wr(A_CTRL, mk(0, 0, 0, 0, 2, 1, 0));

      // R7 PWM, action field set-high ignored
      wr(A_CMPA, 16'd2);
      wr(A_CMPB, 16'd5);
      wr(A_CNT, 16'd0);
      wr(A_CTRL, mk(1, 0, 2, 1, 2, 1, 0));
      e = ncyc;
      push(e + 5,  K_PIN, 16'h1, "R7 high before B");
      push(e + 6,  K_PIN, 16'h0, "R7 B drives low");
      push(e + 8,  K_PIN, 16'h0, "R7 low before A");
      push(e + 9,  K_PIN, 16'h1, "R7 A drives high");
      push(e + 12, K_PIN, 16'h0, "R7 B drives low again");
      idle(14);
      wr(A_CTRL, mk(0, 0, 2, 1, 2, 1, 0));
      idle(3);
      finish_run();
   end
endmodule